// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple word-addressed register bus. Each pin has a direction bit and an alternate-select bit. The direction bit chooses between input and output. The alternate-select bit hands the pad to a peripheral's output and output-enable signals. Pad input values cross into the clock domain through a two-flop synchronizer. The synchronized values are what the port captures and returns on reads.

The data register appears at 256 word-aligned addresses. The address of an access acts as a per-pin mask: address bit 2+n gates pin n. A store therefore changes only the selected pins, with no read-modify-write sequence. A load returns zero in every unselected position.

The bus has no back-pressure. Every write completes in the cycle it is presented. Every read returns its data on `bus_rdata` one clock after `bus_rd` is sampled. The direction register sits at byte offset 0x400 and the alternate-select register at 0x404.

Top module: `gpio_maskport`

## Requirements
- R1: After reset, the direction, alternate-select and stored output registers are all 0. `pad_oe` and `pad_out` are 0 and every pin is a GPIO input.
- R2: `pin_sync` equals `pad_in` delayed by exactly two clock edges, through a two-flop synchronizer.
- R3: The direction register is at address 0x404 minus 4 (0x400). In GPIO mode, a direction bit of 1 sets that pin's `pad_oe` to 1, and a direction bit of 0 sets it to 0.
- R4: A write to any address from 0x000 to 0x3FC with bits [1:0] equal to 0 reaches the data register, using address bits [9:2] as the mask (bit 2+n gates pin n). It updates the stored output bit only where the mask is 1, and it does so whatever the pin's direction.
- R5: A data read returns, one cycle after `bus_rd`, the pin value in positions whose mask bit is 1 and 0 elsewhere. The pin value is the stored bit for output pins and the synchronized input for input pins.
- R6: In GPIO mode, `pad_out` of a pin carries its stored output bit.
- R7: The alternate-select register is at 0x404. Where a bit is 1, `pad_out` and `pad_oe` of that pin follow `alt_out` and `alt_oe`.
- R8: The direction and alternate-select registers read back the full value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 8 | Raw pad input values |
| pin_sync | output | 8 | Synchronized pad input values |
| alt_out | input | 8 | Peripheral output per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |

## Verification
A stored output bit that a masked store wrongly disturbs shows up on `pad_out` of an output pin on the very next cycle. It also shows up in the following full-mask read. A wrong mask decode on reads shows up as nonzero bits in unselected positions one cycle after `bus_rd`. A synchronizer of the wrong depth shows as `pin_sync` moving one edge early or late. A lost configuration write shows on `pad_oe` one cycle after the store.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_ALT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_mp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_sel_e     sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] alt_q,
  output logic [W-1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      alt_q <= '0;
      out_q <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_DIR:  dir_q <= wdata;
        SEL_ALT:  alt_q <= wdata;
        SEL_DATA: out_q <= (out_q & ~mask) | (wdata & mask);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_mp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  reg_sel_e     sel,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] alt_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] rdata
);
  logic [W-1:0] pin_val;
  logic [W-1:0] rd_next;

  always_comb begin
    pin_val = (dir_q & out_q) | (~dir_q & sync_in);
    unique case (sel)
      SEL_DATA: rd_next = pin_val & mask;
      SEL_DIR:  rd_next = dir_q;
      SEL_ALT:  rd_next = alt_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux (
  input  logic use_alt,
  input  logic gpio_out,
  input  logic gpio_oe,
  input  logic per_out,
  input  logic per_oe,
  output logic pad_out,
  output logic pad_oe
);
  always_comb begin
    pad_out = use_alt ? per_out : gpio_out;
    pad_oe  = use_alt ? per_oe  : gpio_oe;
  end
endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport
  import gpio_mp_pkg::*;
#(
  parameter int          N_PINS   = 8,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] DIR_ADDR = 12'h400,
  parameter logic [11:0] ALT_ADDR = 12'h404
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pin_sync,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + N_PINS - 1;

  reg_sel_e          sel;
  logic [N_PINS-1:0] mask;
  logic [N_PINS-1:0] dir_q, alt_q, out_q;

  always_comb begin
    mask = bus_addr[MASK_HI:MASK_LO];
    if (bus_addr[1:0] != 2'b00)                   sel = SEL_NONE;
    else if (bus_addr[ADDR_W-1:MASK_HI+1] == '0)  sel = SEL_DATA;
    else if (bus_addr == ADDR_W'(DIR_ADDR))        sel = SEL_DIR;
    else if (bus_addr == ADDR_W'(ALT_ADDR))        sel = SEL_ALT;
    else                                           sel = SEL_NONE;
  end

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_cfg_regs #(.W(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
    .mask(mask), .dir_q(dir_q), .alt_q(alt_q), .out_q(out_q)
  );

  gpio_rd_mux #(.W(N_PINS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel), .mask(mask),
    .dir_q(dir_q), .alt_q(alt_q), .out_q(out_q), .sync_in(pin_sync),
    .rdata(bus_rdata)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pad
    gpio_pad_mux u_mux (
      .use_alt(alt_q[i]), .gpio_out(out_q[i]), .gpio_oe(dir_q[i]),
      .per_out(alt_out[i]), .per_oe(alt_oe[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
    );
  end
endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk
  import gpio_mp_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] bus_rdata,
  input logic [N_PINS-1:0] pad_in,
  input logic [N_PINS-1:0] pin_sync,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] out_q,
  input logic [N_PINS-1:0] alt_q,
  input reg_sel_e          sel,
  input logic [N_PINS-1:0] mask
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R4: bits outside the write mask keep their stored value
  assert_unmasked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_DATA) |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));

  // R5: unselected read positions return zero
  assert_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_DATA) |=> ((bus_rdata & ~$past(mask)) == '0));

  // R3: direction store reaches pad_oe next cycle for GPIO-mode pins
  assert_dir_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_DIR && alt_q == '0) |=> (pad_oe == $past(bus_wdata)));

  // R2: two-edge synchronizer latency
  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (pin_sync == $past(pad_in, 2)));
endmodule

bind gpio_maskport gpio_maskport_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pin_sync(pin_sync), .pad_oe(pad_oe),
  .out_q(out_q), .alt_q(alt_q), .sel(sel), .mask(mask)
);

// File: tb/gpio_maskport_bench.sv
module gpio_maskport_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0] bus_rdata, pin_sync, pad_out, pad_oe;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gpio_maskport u_gpio_maskport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pin_sync(pin_sync), .alt_out(alt_out),
    .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {mask, write data, expected stored value after the write}
  localparam logic [23:0] WTAB [6] = '{
    24'hFF_A5_A5, 24'h0F_00_A0, 24'h81_FF_A1,
    24'h3C_5A_99, 24'h00_FF_99, 24'h18_00_81
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] daddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    rd(12'h400, v); chk("R1 dir", v, 8'h00);
    rd(12'h404, v); chk("R1 alt", v, 8'h00);

    wr(12'h400, 8'hFF);
    chk("R3 pad_oe all out", pad_oe, 8'hFF);
    rd(12'h400, v); chk("R8 dir readback", v, 8'hFF);

    for (int i = 0; i < 6; i++) begin
      wr(daddr(WTAB[i][23:16]), WTAB[i][15:8]);
      chk("R6 pad_out after masked write", pad_out, WTAB[i][7:0]);
      rd(daddr(8'hFF), v);
      chk("R4 stored value", v, WTAB[i][7:0]);
    end

    rd(daddr(8'h0F), v); chk("R5 masked read output pins", v, 8'h01);

    wr(12'h400, 8'h0F);
    chk("R3 pad_oe low nibble", pad_oe, 8'h0F);
    @(negedge clk); pad_in = 8'hC3;
    @(negedge clk); chk("R2 one edge", pin_sync, 8'h00);
    @(negedge clk); chk("R2 two edges", pin_sync, 8'hC3);
    rd(daddr(8'hF0), v); chk("R5 masked read input pins", v, 8'hC0);
    rd(daddr(8'hFF), v); chk("R5 mixed read", v, 8'hC1);
    rd(daddr(8'h24), v); chk("R5 sparse mask", v, 8'h00);

    wr(daddr(8'hF0), 8'hFF);
    chk("R4 write to input pins hidden", pad_out, 8'hF1);
    wr(12'h400, 8'hFF);
    rd(daddr(8'hFF), v); chk("R4 stored on input pins", v, 8'hF1);
    wr(12'h400, 8'h0F);

    alt_out = 8'h02; alt_oe = 8'h01;
    wr(12'h404, 8'h03);
    chk("R7 alt pad_out", pad_out, 8'hF2);
    chk("R7 alt pad_oe", pad_oe, 8'h0D);
    rd(12'h404, v); chk("R8 alt readback", v, 8'h03);

    wr(12'h402, 8'hFF);
    rd(12'h400, v); chk("R3 unaligned write ignored", v, 8'h0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule